// File: doc/BRIEF.md
# Handshaked Memory Transfer Sequencer

This block steers one load or one store at a time between a CPU register file and main memory. The datapath has a single internal bus. A request names the direction, the register that holds the memory address, and the register that supplies the data for a store or receives it for a load. The sequencer puts the register file, the memory address register (MAR) and the memory buffer register (MBR) onto the shared bus in turn, one source per cycle. Every destination latches the bus at the clock edge.

Memory accesses finish through a completion handshake. The sequencer raises a read or write strobe and holds it until the memory answers with a function-complete pulse (`mem_mfc`). The answer can come after any number of cycles. The MAR drives the external address lines. The MBR connects to the external data lines.

An optional watchdog abandons an access that gets no answer within a set number of strobe cycles and reports it with a one-cycle error pulse. The register file is outside the block. The sequencer supplies its read index and its write index and write enable. The register file returns the selected word combinationally.

Top module: `memxfer_seq`

## Requirements
- R1: After reset, `busy`, `mem_read`, `mem_write`, `drv_reg`, `drv_mbr`, `reg_we` and `timeout_err` are all low.
- R2: In any cycle, at most one of `drv_reg` and `drv_mbr` is high. `bus_data` equals `reg_rdata` when `drv_reg` is high, and equals the MBR when `drv_mbr` is high.
- R3: A request is accepted in a cycle where `req_valid` is high and the block is idle. In the next cycle, the register at `req_addr_idx` drives the bus and the MAR loads it, with no strobe high. In the cycle after that, a load raises `mem_read` with `mem_addr` equal to the low AW bits of that register. `mem_read` and `mem_write` are never high together.
- R4: A load holds `mem_read` until it samples `mem_mfc` high, and the MBR captures `mem_rdata` in that cycle. In the next cycle, `mem_read` is low, `drv_mbr` and `reg_we` are high, `reg_wr_idx` is the data index, and `bus_data` is the captured word. `busy` is low in the cycle after that.
- R5: A store drives the bus from the register at `req_addr_idx` into the MAR in the first cycle. In the second cycle, the register at `req_data_idx` drives the bus into the MBR and `mem_write` rises in that same cycle. `mem_wdata` shows the stored word from then on.
- R6: A store holds `mem_write` until it samples `mem_mfc` high. This may happen as early as the MBR load cycle. In the cycle after `mem_mfc`, both `mem_write` and `busy` are low.
- R7: `busy` rises in the cycle after acceptance and stays high through the final transfer cycle. While `busy` is high, `req_valid` has no effect on the transfer in progress, and no further transfer follows from it.
- R8: `mem_mfc` is ignored in cycles where neither strobe is high.
- R9: With `TIMEOUT` > 0, a strobe that stays high for `TIMEOUT` cycles without `mem_mfc` abandons the transfer. In the next cycle, the strobes and `busy` are low and `timeout_err` is high for exactly one cycle. No register write takes place. A `mem_mfc` in the `TIMEOUT`-th strobe cycle still completes the transfer normally. `TIMEOUT` = 0 removes the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr_idx | input | IW | Index of the register holding the memory address |
| req_data_idx | input | IW | Index of the store source or load destination register |
| busy | output | 1 | A transfer is in progress |
| reg_rd_idx | output | IW | Register file read index |
| reg_rdata | input | DW | Register file word at `reg_rd_idx` |
| drv_reg | output | 1 | Register file drives the internal bus |
| drv_mbr | output | 1 | MBR drives the internal bus |
| bus_data | output | DW | Internal bus value; register file write data |
| reg_we | output | 1 | Register file write enable |
| reg_wr_idx | output | IW | Register file write index |
| mem_addr | output | AW | External address (MAR) |
| mem_wdata | output | DW | External write data (MBR) |
| mem_rdata | input | DW | External read data |
| mem_read | output | 1 | Read strobe |
| mem_write | output | 1 | Write strobe |
| mem_mfc | input | 1 | Memory function complete |
| timeout_err | output | 1 | One-cycle pulse when an access is abandoned |

## Verification
A wrong sequencer state shows at the ports within one cycle:
- a missing or doubled bus driver;
- a strobe that rises before the MAR is loaded;
- a strobe that drops without a completion pulse;
- a write-back that happens a cycle late.

A wrong MAR or MBR value shows the cycle the strobe is up, as a wrong `mem_addr` or `mem_wdata`, or as a wrong register word one cycle after a load completes. A watchdog counter that is off by one moves `timeout_err` one cycle away from the `TIMEOUT`-th strobe cycle. The same error either rejects or accepts a completion at the boundary, and that flips the register or memory result.

// File: rtl/memxfer_pkg.sv
package memxfer_pkg;

   // Sequencer phases; one internal-bus transfer per phase at most.
   typedef enum logic [2:0] {
      ST_IDLE,   // waiting for a request
      ST_ADDR,   // address register -> bus -> MAR
      ST_DATA,   // store only: data register -> bus -> MBR, write strobe up
      ST_WAIT,   // strobe held, waiting for completion
      ST_BACK    // load only: MBR -> bus -> destination register
   } xfer_st_e;

   // Source currently driving the internal bus.
   typedef enum logic [1:0] {
      SRC_NONE,
      SRC_REG,
      SRC_MBR
   } bus_src_e;

endpackage

// File: rtl/memxfer_timer.sv
module memxfer_timer #(
   parameter int TIMEOUT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,    // a memory strobe is high this cycle
   input  logic run,       // strobe high and no completion this cycle
   output logic expired    // this is the last allowed strobe cycle, still no completion
);

   generate
      if (TIMEOUT > 0) begin : g_timer
         localparam int CW = $clog2(TIMEOUT + 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n)      cnt_q <= '0;
            else if (!strobe) cnt_q <= '0;
            else if (run)    cnt_q <= cnt_q + 1'b1;
         end

         assign expired = run && (cnt_q == CW'(TIMEOUT - 1));
      end else begin : g_no_timer
         logic unused_inputs;
         assign unused_inputs = ^{clk, rst_n, strobe, run};
         assign expired       = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/memxfer_path.sv
module memxfer_path
   import memxfer_pkg::*;
#(
   parameter int DW = 16,
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  bus_src_e      src,
   input  logic [DW-1:0] reg_rdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mar_load,
   input  logic          mbr_load_bus,
   input  logic          mbr_load_mem,
   output logic [DW-1:0] bus,
   output logic [AW-1:0] mar,
   output logic [DW-1:0] mbr
);

   logic [AW-1:0] mar_q;
   logic [DW-1:0] mbr_q;

   // The one shared internal bus.
   always_comb begin
      unique case (src)
         SRC_REG: bus = reg_rdata;
         SRC_MBR: bus = mbr_q;
         default: bus = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        mar_q <= '0;
      else if (mar_load) mar_q <= bus[AW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)            mbr_q <= '0;
      else if (mbr_load_mem) mbr_q <= mem_rdata;
      else if (mbr_load_bus) mbr_q <= bus;
   end

   assign mar = mar_q;
   assign mbr = mbr_q;

endmodule

// File: rtl/memxfer_fsm.sv
module memxfer_fsm
   import memxfer_pkg::*;
#(
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_store,
   input  logic [IW-1:0] req_addr_idx,
   input  logic [IW-1:0] req_data_idx,
   input  logic          mfc,
   input  logic          expired,
   output xfer_st_e      state,
   output logic          is_store,
   output logic [IW-1:0] addr_idx,
   output logic [IW-1:0] data_idx,
   output logic          err
);

   xfer_st_e      st_q, st_d;
   logic          store_q;
   logic [IW-1:0] aidx_q, didx_q;
   logic          err_q, abort;

   assign abort = ((st_q == ST_DATA) || (st_q == ST_WAIT)) && !mfc && expired;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (req_valid) st_d = ST_ADDR;
         ST_ADDR: st_d = store_q ? ST_DATA : ST_WAIT;
         ST_DATA: begin
            if (mfc || abort) st_d = ST_IDLE;
            else              st_d = ST_WAIT;
         end
         ST_WAIT: begin
            if (mfc)        st_d = store_q ? ST_IDLE : ST_BACK;
            else if (abort) st_d = ST_IDLE;
         end
         ST_BACK: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         store_q <= 1'b0;
         aidx_q  <= '0;
         didx_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         st_q  <= st_d;
         err_q <= abort;
         if (st_q == ST_IDLE && req_valid) begin
            store_q <= req_store;
            aidx_q  <= req_addr_idx;
            didx_q  <= req_data_idx;
         end
      end
   end

   assign state    = st_q;
   assign is_store = store_q;
   assign addr_idx = aidx_q;
   assign data_idx = didx_q;
   assign err      = err_q;

endmodule

// File: rtl/memxfer_seq.sv
module memxfer_seq
   import memxfer_pkg::*;
#(
   parameter int DW      = 16,
   parameter int AW      = 8,
   parameter int NREG    = 8,
   parameter int TIMEOUT = 16,
   localparam int IW     = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_store,
   input  logic [IW-1:0] req_addr_idx,
   input  logic [IW-1:0] req_data_idx,
   output logic          busy,
   output logic [IW-1:0] reg_rd_idx,
   input  logic [DW-1:0] reg_rdata,
   output logic          drv_reg,
   output logic          drv_mbr,
   output logic [DW-1:0] bus_data,
   output logic          reg_we,
   output logic [IW-1:0] reg_wr_idx,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          mem_read,
   output logic          mem_write,
   input  logic          mem_mfc,
   output logic          timeout_err
);

   generate
      if (AW > DW) begin : g_bad_aw
         $error("memxfer_seq: AW must not exceed DW");
      end
      if (NREG < 2) begin : g_bad_nreg
         $error("memxfer_seq: NREG must be at least 2");
      end
      if (TIMEOUT < 0) begin : g_bad_timeout
         $error("memxfer_seq: TIMEOUT must be non-negative");
      end
   endgenerate

   xfer_st_e      state;
   logic          is_store;
   logic [IW-1:0] addr_idx, data_idx;
   logic          expired, strobe;
   bus_src_e      src;
   logic          mar_load, mbr_load_bus, mbr_load_mem;
   logic [AW-1:0] mar;
   logic [DW-1:0] mbr, bus;

   memxfer_fsm #(.IW(IW)) fsm_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_store    (req_store),
      .req_addr_idx (req_addr_idx),
      .req_data_idx (req_data_idx),
      .mfc          (mem_mfc),
      .expired      (expired),
      .state        (state),
      .is_store     (is_store),
      .addr_idx     (addr_idx),
      .data_idx     (data_idx),
      .err          (timeout_err)
   );

   // Control decode per phase.
   always_comb begin
      src          = SRC_NONE;
      mar_load     = 1'b0;
      mbr_load_bus = 1'b0;
      mbr_load_mem = 1'b0;
      mem_read     = 1'b0;
      mem_write    = 1'b0;
      reg_we       = 1'b0;
      reg_rd_idx   = addr_idx;
      unique case (state)
         ST_ADDR: begin
            src      = SRC_REG;
            mar_load = 1'b1;
         end
         ST_DATA: begin
            src          = SRC_REG;
            reg_rd_idx   = data_idx;
            mbr_load_bus = 1'b1;
            mem_write    = 1'b1;
         end
         ST_WAIT: begin
            mem_read     = !is_store;
            mem_write    = is_store;
            mbr_load_mem = !is_store && mem_mfc;
         end
         ST_BACK: begin
            src    = SRC_MBR;
            reg_we = 1'b1;
         end
         default: ;
      endcase
   end

   assign strobe = mem_read || mem_write;

   memxfer_timer #(.TIMEOUT(TIMEOUT)) timer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe  (strobe),
      .run     (strobe && !mem_mfc),
      .expired (expired)
   );

   memxfer_path #(.DW(DW), .AW(AW)) path_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .src          (src),
      .reg_rdata    (reg_rdata),
      .mem_rdata    (mem_rdata),
      .mar_load     (mar_load),
      .mbr_load_bus (mbr_load_bus),
      .mbr_load_mem (mbr_load_mem),
      .bus          (bus),
      .mar          (mar),
      .mbr          (mbr)
   );

   assign busy       = (state != ST_IDLE);
   assign drv_reg    = (src == SRC_REG);
   assign drv_mbr    = (src == SRC_MBR);
   assign bus_data   = bus;
   assign reg_wr_idx = data_idx;
   assign mem_addr   = mar;
   // In the MBR load cycle the word is forwarded from the bus.
   assign mem_wdata  = (state == ST_DATA) ? bus : mbr;

endmodule

// File: rtl/memxfer_seq_chk.sv
module memxfer_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic busy,
   input logic drv_reg,
   input logic drv_mbr,
   input logic reg_we,
   input logic mem_read,
   input logic mem_write,
   input logic mem_mfc,
   input logic timeout_err
);

   p_one_driver_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({drv_reg, drv_mbr}));

   p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_read && mem_write));

   p_read_after_mar_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_read) |-> $past(drv_reg));

   p_read_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_read && !mem_mfc) |=> (mem_read || timeout_err));

   p_read_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_read && mem_mfc) |=> (!mem_read && reg_we && drv_mbr));

   p_we_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> busy);

   p_write_with_mbr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_write) |-> drv_reg);

   p_write_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_write && !mem_mfc) |=> (mem_write || timeout_err));

   p_write_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_write && mem_mfc) |=> (!mem_write && !busy));

   p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));

   p_err_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |-> (!busy && !mem_read && !mem_write));

   p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |=> !timeout_err);

endmodule

bind memxfer_seq memxfer_seq_chk chk_i (.*);

// File: tb/memxfer_seq_tb.sv
`timescale 1ns/1ps
module memxfer_seq_tb_top;

   localparam int DW      = 16;
   localparam int AW      = 8;
   localparam int NREG    = 8;
   localparam int TIMEOUT = 16;
   localparam int IW      = (NREG > 1) ? $clog2(NREG) : 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_store = 1'b0;
   logic [IW-1:0] req_addr_idx = '0, req_data_idx = '0;
   logic          busy, drv_reg, drv_mbr, reg_we, mem_read, mem_write, timeout_err;
   logic [IW-1:0] reg_rd_idx, reg_wr_idx;
   logic [DW-1:0] reg_rdata, bus_data, mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic [AW-1:0] mem_addr;
   logic          mem_mfc = 1'b0;

   int  n_chk = 0, n_fail = 0;
   bit  done = 1'b0;
   bit  init_en = 1'b1;

   logic [DW-1:0] regs [NREG];
   logic [DW-1:0] mem  [1 << AW];

   always #2.5 clk = ~clk;

   memxfer_seq #(.DW(DW), .AW(AW), .NREG(NREG), .TIMEOUT(TIMEOUT)) dut_i (.*);

   // Register file and memory models outside the block.
   assign reg_rdata = regs[reg_rd_idx];

   always @(posedge clk) begin
      if (init_en) begin
         for (int i = 0; i < NREG; i++) regs[i] <= DW'($urandom);
         for (int i = 0; i < (1 << AW); i++) mem[i] <= DW'($urandom);
      end else begin
         if (reg_we) regs[reg_wr_idx] <= bus_data;
         if (mem_mfc && mem_write) mem[mem_addr] <= mem_wdata;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic bit expect_timeout(input int lat);
      return (TIMEOUT > 0) && (lat >= TIMEOUT);
   endfunction

   // One transfer; lat = strobe cycles before the completion pulse.
   task automatic do_xfer(input bit st, input int a, input int d, input int lat);
      logic [DW-1:0] av, dv, exp_v, pre_reg, pre_mem;
      logic [AW-1:0] addr;
      bit hit = 1'b0;
      av = regs[a]; dv = regs[d]; addr = av[AW-1:0];
      pre_reg = regs[d]; pre_mem = mem[addr]; exp_v = mem[addr];
      req_valid = 1'b1; req_store = st;
      req_addr_idx = IW'(a); req_data_idx = IW'(d);
      @(negedge clk);
      // R3/R5 address phase; stray request and completion must be ignored (R7, R8)
      req_valid = 1'($urandom % 2); req_store = 1'($urandom);
      req_addr_idx = IW'($urandom); req_data_idx = IW'($urandom);
      mem_mfc = 1'($urandom % 2);
      chk("R3 addr phase flags", {busy, drv_reg, drv_mbr, mem_read, mem_write}, 5'b11000);
      chk("R3 addr phase idx", reg_rd_idx, a);
      chk("R2 bus from reg", bus_data, av);
      @(negedge clk);
      mem_mfc = 1'b0;
      for (int n = 0; n < TIMEOUT; n++) begin
         chk("R3 strobe read", mem_read, !st);
         chk("R5 strobe write", mem_write, st);
         chk("R3 mem_addr", mem_addr, addr);
         chk("R7 busy in strobe", busy, 1'b1);
         if (st) chk("R5 mem_wdata", mem_wdata, dv);
         if (st && n == 0) begin
            chk("R5 mbr load flags", {drv_reg, drv_mbr}, 2'b10);
            chk("R5 data idx", reg_rd_idx, d);
            chk("R2 bus data", bus_data, dv);
         end else begin
            chk("R2 no driver", {drv_reg, drv_mbr}, 2'b00);
         end
         req_valid = 1'($urandom % 2);
         if (n == lat) begin
            mem_mfc = 1'b1; hit = 1'b1;
            mem_rdata = mem[addr];
         end else begin
            mem_rdata = DW'($urandom);
         end
         @(negedge clk);
         mem_mfc = 1'b0;
         if (hit) break;
      end
      req_valid = 1'b0;
      if (!hit && TIMEOUT == 0) return;
      chk("R9 timeout expectation", !hit, expect_timeout(lat));
      if (hit && !st) begin
         chk("R4 write-back flags", {busy, mem_read, drv_reg, drv_mbr, reg_we}, 5'b10011);
         chk("R4 wr idx", reg_wr_idx, d);
         chk("R4 bus word", bus_data, exp_v);
         @(negedge clk);
         chk("R4 busy low after write-back", busy, 1'b0);
         chk("R4 register loaded", regs[d], exp_v);
         chk("R9 no error", timeout_err, 1'b0);
      end else if (hit && st) begin
         chk("R6 store ended", {busy, mem_write}, 2'b00);
         chk("R6 memory written", mem[addr], dv);
         chk("R9 no error", timeout_err, 1'b0);
      end else begin
         chk("R9 abort flags", {timeout_err, busy, mem_read, mem_write, reg_we}, 5'b10000);
         chk("R9 register unchanged", regs[d], pre_reg);
         chk("R9 memory unchanged", mem[addr], pre_mem);
         @(negedge clk);
         chk("R9 error one cycle", timeout_err, 1'b0);
      end
      @(negedge clk);
      chk("R7 no phantom transfer", {busy, mem_read, mem_write}, 3'b000);
   endtask

   initial begin
      void'($urandom(32'h0BEE5));
      repeat (3) @(negedge clk);
      chk("R1 reset state", {busy, mem_read, mem_write, drv_reg, drv_mbr, reg_we, timeout_err}, 7'b0);
      init_en = 1'b0;
      rst_n   = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", {busy, mem_read, mem_write, drv_reg, drv_mbr, reg_we, timeout_err}, 7'b0);
      // R8: completion pulse while idle
      mem_mfc = 1'b1;
      @(negedge clk);
      mem_mfc = 1'b0;
      chk("R8 idle mfc ignored", {busy, mem_read, mem_write, timeout_err}, 4'b0);
      // directed corners
      do_xfer(1'b0, 1, 2, 0);
      do_xfer(1'b1, 3, 4, 0);            // R6 completion in the MBR load cycle
      do_xfer(1'b0, 5, 5, 3);            // same register for address and data
      do_xfer(1'b1, 6, 6, 2);
      do_xfer(1'b0, 2, 7, TIMEOUT - 1);  // R9 boundary, accepted
      do_xfer(1'b1, 0, 1, TIMEOUT - 1);
      do_xfer(1'b0, 4, 3, TIMEOUT);      // R9 abandoned
      do_xfer(1'b1, 7, 0, TIMEOUT);
      for (int t = 0; t < 400; t++) begin
         int lat;
         lat = ($urandom % 8 == 0) ? int'($urandom % 20) : int'($urandom % 5);
         do_xfer(1'($urandom), int'($urandom % NREG), int'($urandom % NREG), lat);
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R7 watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule